// File: doc/BRIEF.md
# UART Register File with Interrupt

This block is the register-side front end of a simple serial port. A host reaches it over a 32-bit register bus that uses byte addresses. The block drops the two low address bits and decodes a word index from the rest. The block holds the control words, the status words and a receive holding register that stores a single character. It also holds a few registers that software writes and reads back but that have no effect on the line.

Characters and break events arrive from a line-side receiver over a valid/ready handshake. The receiver is held off while the holding register is occupied. Bytes that software writes for transmission go out to a line-side transmitter over a second valid/ready handshake. While a byte waits to be accepted, the transmit-ready status bits read low. A single level interrupt is formed by masking status bits with enable bits from the control words.

Some status bits clear when software writes a 1 to them, and the rest ignore writes. Writing 0 to the soft-reset bit of the second control word restores most of the state.

Top module: `uart_regfile`

## Requirements
- R1: After rst_ni these reads return: status A (index 0x25) 0x6040, status B (0x26) 0x4028, test word (0x2D) 0x0060, control A (0x20) 0, control B (0x21) 0x0001, control C (0x22) 0x0700, baud count (0x2B) 0x0004. A receive read (0x00) returns 0x4000, which is the error flag (bit 14) without the valid flag. irq_o is low.
- R2: Each write to control A–D (0x20–0x23), FIFO control (0x24), baud modulator (0x2A) or the millisecond word (0x2C) stores only wdata bits 15:0. A write to the baud increment index (0x29) loads the baud count register, which reads back at 0x2B. A read of 0x29 returns 0. Reads of unmapped indices return 0. Writes to 0x2B and 0x2D change nothing.
- R3: When rx_valid_i is high and rx_ready_o is high, the block stores the character. It then sets RRDY (status A bit 9) and RDR (status B bit 0), clears RX-empty (test bit 5) and drops rx_ready_o. A beat offered while the holding register is full is not taken.
- R4: A receive read with a character held returns the character with bit 15 set. The same read clears RRDY and RDR and sets RX-empty. A receive read while empty returns the stored value with bit 15 clear.
- R5: A beat with rx_break_i high stores 0x5800 (bits 14, 12 and 11) and sets BRCD (status B bit 2). BRCD clears when software writes a 1 to it.
- R6: A write to index 0x10 is sent to the transmitter only when control B bit 2 is set. While the byte is pending, TRDY (status A bit 13) and TXDC (status B bit 3) read 0. Both return to 1 once tx_ready_i accepts the byte. A transmit write made while a byte is pending is dropped.
- R7: A 1 written to status A clears only bits 15, 12, 11, 10, 8, 7, 5 and 4. A 1 written to status B clears only bits 15, 13, 12, 11, 10, 8, 7, 6, 4, 2 and 1. All other status bits ignore writes.
- R8: A write to control B with bit 0 low performs a soft reset. Control A, control C, the baud modulator, the baud count, both status words, the receive holding register and any pending transmit byte return to their R1 values. Control D, FIFO control and the millisecond word keep their values. Control B stores the written value with bit 0 forced to 1.
- R9: irq_o is high when any of these holds: TRDY and control A bit 13 are both set; RRDY and control A bit 9 are both set; TXFE (status B bit 14) and control A bit 6 are both set; TXDC and control D bit 3 are both set; RDR and control D bit 0 are both set.
- R10: A read returns its data on rdata_o after the clock edge that samples the request. rdata_o holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; bits 1:0 ignored |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| rx_valid_i | input | 1 | Receiver offers a character or a break |
| rx_break_i | input | 1 | The offered beat is a break event |
| rx_data_i | input | CHAR_W | Received character |
| rx_ready_o | output | 1 | Holding register is free |
| tx_valid_o | output | 1 | Transmit byte pending |
| tx_data_o | output | CHAR_W | Transmit byte |
| tx_ready_i | input | 1 | Transmitter accepts the byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters: a 12-bit byte address, a 32-bit data bus and 8-bit characters. With a 12-bit address, every defined index can be reached, and so can an unmapped index above them. The 32-bit bus lets the bench write values with the upper half set, which shows that the 16-bit truncation works. The 8-bit character leaves the valid, error and break flag positions clear of the data, so a read that mixes a character with flags can be decoded without ambiguity.

// File: rtl/urf_pkg.sv
package urf_pkg;
  localparam int REG_W = 16;

  localparam logic [5:0] IDX_RXD   = 6'h00;
  localparam logic [5:0] IDX_TXD   = 6'h10;
  localparam logic [5:0] IDX_CTLA  = 6'h20;
  localparam logic [5:0] IDX_CTLB  = 6'h21;
  localparam logic [5:0] IDX_CTLC  = 6'h22;
  localparam logic [5:0] IDX_CTLD  = 6'h23;
  localparam logic [5:0] IDX_FIFO  = 6'h24;
  localparam logic [5:0] IDX_STA   = 6'h25;
  localparam logic [5:0] IDX_STB   = 6'h26;
  localparam logic [5:0] IDX_BINC  = 6'h29;
  localparam logic [5:0] IDX_BMOD  = 6'h2A;
  localparam logic [5:0] IDX_BCNT  = 6'h2B;
  localparam logic [5:0] IDX_MSEC  = 6'h2C;
  localparam logic [5:0] IDX_TEST  = 6'h2D;

  // shared positions: status A and control A
  localparam int B_TRDY     = 13;
  localparam int B_RRDY     = 9;
  localparam int B_TXMPTYEN = 6;
  // status B, aligned with control D enables
  localparam int B_TXFE     = 14;
  localparam int B_TXDC     = 3;
  localparam int B_BRCD     = 2;
  localparam int B_RDR      = 0;
  // control B
  localparam int B_SRST     = 0;
  localparam int B_TXEN     = 2;
  // test word
  localparam int B_RXEMPTY  = 5;
  // receive word flags
  localparam int B_CHARRDY  = 15;

  localparam logic [REG_W-1:0] STA_RST   = 16'h4040; // stored bits only
  localparam logic [REG_W-1:0] STB_RST   = 16'h4020;
  localparam logic [REG_W-1:0] TEST_RST  = 16'h0060;
  localparam logic [REG_W-1:0] CTLB_RST  = 16'h0001;
  localparam logic [REG_W-1:0] CTLC_RST  = 16'h0700;
  localparam logic [REG_W-1:0] BCNT_RST  = 16'h0004;
  localparam logic [REG_W-1:0] RXB_RST   = 16'h4000;
  localparam logic [REG_W-1:0] RXB_BREAK = 16'h5800;

  localparam logic [REG_W-1:0] STA_W1C = 16'h9DB0;
  localparam logic [REG_W-1:0] STB_W1C = 16'hBDD6;
endpackage

// File: rtl/urf_rx_buf.sv
module urf_rx_buf
  import urf_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              valid_i,
  input  logic              brk_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              drain_i,
  output logic              ready_o,
  output logic              brk_evt_o,
  output logic              full_o,
  output logic [REG_W-1:0]  buf_o
);
  localparam int PAD_W = REG_W - CHAR_W;

  logic             full_q;
  logic [REG_W-1:0] buf_q;
  logic             take;

  assign ready_o   = ~full_q;
  assign take      = valid_i & ~full_q;
  assign brk_evt_o = take & brk_i;
  assign full_o    = full_q;
  assign buf_o     = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      buf_q  <= RXB_RST;
    end else if (srst_i) begin
      full_q <= 1'b0;
      buf_q  <= RXB_RST;
    end else if (take) begin
      full_q <= 1'b1;
      buf_q  <= brk_i ? RXB_BREAK : {{PAD_W{1'b0}}, data_i};
    end else if (drain_i) begin
      full_q <= 1'b0;
    end
  end

  p_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && !srst_i) |=> (full_o && !ready_o));
  p_hold_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !drain_i && !srst_i) |=> (full_o && $stable(buf_o)));
  p_drain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && drain_i) |=> !full_o);
endmodule

// File: rtl/urf_tx_port.sv
module urf_tx_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              load_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [CHAR_W-1:0] tx_data_o,
  output logic              busy_o
);
  logic              pend_q;
  logic [CHAR_W-1:0] data_q;

  assign tx_valid_o = pend_q;
  assign tx_data_o  = data_q;
  assign busy_o     = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (srst_i) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      if (tx_ready_i) pend_q <= 1'b0;   // writes while pending are dropped
    end else if (load_i) begin
      pend_q <= 1'b1;
      data_q <= data_i;
    end
  end

  p_tx_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !srst_i) |=> (tx_valid_o && $stable(tx_data_o)));
  p_tx_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i) |=> !tx_valid_o);
endmodule

// File: rtl/urf_irq.sv
module urf_irq
  import urf_pkg::*;
(
  input  logic [REG_W-1:0] sta_i,
  input  logic [REG_W-1:0] stb_i,
  input  logic [REG_W-1:0] ctla_i,
  input  logic [REG_W-1:0] ctld_i,
  output logic             irq_o
);
  logic [REG_W-1:0] a_sel, b_mask;

  always_comb begin
    a_sel = '0;
    a_sel[B_TRDY] = 1'b1;
    a_sel[B_RRDY] = 1'b1;
    b_mask = '0;
    b_mask[B_TXFE] = ctla_i[B_TXMPTYEN];
    b_mask[B_TXDC] = ctld_i[B_TXDC];
    b_mask[B_RDR]  = ctld_i[B_RDR];
  end

  assign irq_o = |(sta_i & ctla_i & a_sel) | |(stb_i & b_mask);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import urf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_valid_i,
  input  logic              rx_break_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [CHAR_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - REG_W;

  logic [5:0]       idx;
  logic             hi_ok;
  logic             wr, rd;
  logic [REG_W-1:0] wd;

  generate
    if (ADDR_W > 8) begin : g_hi
      assign hi_ok = ~|addr_i[ADDR_W-1:8];
    end else begin : g_nohi
      assign hi_ok = 1'b1;
    end
  endgenerate

  assign idx = addr_i[7:2];
  assign wr  = req_i & we_i & hi_ok;
  assign rd  = req_i & ~we_i;
  assign wd  = wdata_i[REG_W-1:0];

  logic unused_ok;
  assign unused_ok = ^{wdata_i[DATA_W-1:REG_W], addr_i[1:0]};

  logic [REG_W-1:0] ctla_q, ctlb_q, ctlc_q, ctld_q, fifo_q, bmod_q, bcnt_q, msec_q;
  logic [REG_W-1:0] sta_q, stb_q;
  logic [REG_W-1:0] sta, stb, test_w, rxb;
  logic             srst, rx_full, brk_evt, tx_busy, drain, tx_load;
  logic [REG_W-1:0] rmux;
  logic [DATA_W-1:0] rdata_q;

  assign srst    = wr && idx == IDX_CTLB && !wd[B_SRST];
  assign tx_load = wr && idx == IDX_TXD && ctlb_q[B_TXEN];

  urf_rx_buf #(.CHAR_W(CHAR_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst),
    .valid_i   (rx_valid_i),
    .brk_i     (rx_break_i),
    .data_i    (rx_data_i),
    .drain_i   (drain),
    .ready_o   (rx_ready_o),
    .brk_evt_o (brk_evt),
    .full_o    (rx_full),
    .buf_o     (rxb)
  );

  urf_tx_port #(.CHAR_W(CHAR_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (srst),
    .load_i     (tx_load),
    .data_i     (wd[CHAR_W-1:0]),
    .tx_ready_i (tx_ready_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .busy_o     (tx_busy)
  );

  // live bits overlay the stored status
  always_comb begin
    sta = sta_q;
    sta[B_TRDY] = ~tx_busy;
    sta[B_RRDY] = rx_full;
    stb = stb_q;
    stb[B_TXDC] = ~tx_busy;
    stb[B_RDR]  = rx_full;
    test_w = TEST_RST;
    test_w[B_RXEMPTY] = ~rx_full;
  end

  urf_irq u_irq (
    .sta_i  (sta),
    .stb_i  (stb),
    .ctla_i (ctla_q),
    .ctld_i (ctld_q),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctla_q <= '0;
      ctlb_q <= CTLB_RST;
      ctlc_q <= CTLC_RST;
      ctld_q <= '0;
      fifo_q <= '0;
      bmod_q <= '0;
      bcnt_q <= BCNT_RST;
      msec_q <= '0;
      sta_q  <= STA_RST;
      stb_q  <= STB_RST;
    end else if (srst) begin
      ctla_q <= '0;
      ctlb_q <= wd | CTLB_RST;
      ctlc_q <= CTLC_RST;
      bmod_q <= '0;
      bcnt_q <= BCNT_RST;
      sta_q  <= STA_RST;
      stb_q  <= STB_RST;
    end else begin
      if (wr) begin
        unique case (idx)
          IDX_CTLA: ctla_q <= wd;
          IDX_CTLB: ctlb_q <= wd;
          IDX_CTLC: ctlc_q <= wd;
          IDX_CTLD: ctld_q <= wd;
          IDX_FIFO: fifo_q <= wd;
          IDX_BINC: bcnt_q <= wd;
          IDX_BMOD: bmod_q <= wd;
          IDX_MSEC: msec_q <= wd;
          IDX_STA:  sta_q  <= sta_q & ~(wd & STA_W1C);
          default: ;
        endcase
      end
      if (wr && idx == IDX_STB)
        stb_q <= (stb_q & ~(wd & STB_W1C)) | (brk_evt ? (REG_W'(1) << B_BRCD) : '0);
      else if (brk_evt)
        stb_q[B_BRCD] <= 1'b1;
    end
  end

  always_comb begin
    rmux = '0;
    if (hi_ok) begin
      unique case (idx)
        IDX_RXD:  begin
          rmux = rxb;
          rmux[B_CHARRDY] = rx_full;
        end
        IDX_CTLA: rmux = ctla_q;
        IDX_CTLB: rmux = ctlb_q;
        IDX_CTLC: rmux = ctlc_q;
        IDX_CTLD: rmux = ctld_q;
        IDX_FIFO: rmux = fifo_q;
        IDX_STA:  rmux = sta;
        IDX_STB:  rmux = stb;
        IDX_BMOD: rmux = bmod_q;
        IDX_BCNT: rmux = bcnt_q;
        IDX_MSEC: rmux = msec_q;
        IDX_TEST: rmux = test_w;
        default:  rmux = '0;
      endcase
    end
  end

  assign drain = rd && hi_ok && idx == IDX_RXD && rx_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= {{PAD_W{1'b0}}, rmux};
  end
  assign rdata_o = rdata_q;

  p_srst_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx == IDX_CTLB) |=> ctlb_q[B_SRST]);
  p_srst_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (ctla_q == '0 && !rx_full && !tx_valid_o));
  p_binc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx == IDX_BINC) |=> bcnt_q == $past(wdata_i[REG_W-1:0]));
  p_irq_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctla_q == '0 && ctld_q == '0) |-> !irq_o);
  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, tx_ready = 1'b0, irq;
  logic [7:0]  tx_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid),
    .rx_break_i(rx_break), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .irq_o(irq)
  );

  task automatic chk(string req_tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req_tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] idx, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = {4'h0, idx, 2'b00}; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic rdi(logic [5:0] idx, output logic [31:0] d);
    rd({4'h0, idx, 2'b00}, d);
  endtask

  task automatic rx_beat(logic [7:0] c, logic brk);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = c; rx_break = brk;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rdi(6'h25, d); chk("R1 status A", d, 32'h6040);
    rdi(6'h26, d); chk("R1 status B", d, 32'h4028);
    rdi(6'h2D, d); chk("R1 test", d, 32'h0060);
    rdi(6'h20, d); chk("R1 control A", d, 32'h0);
    rdi(6'h21, d); chk("R1 control B", d, 32'h0001);
    rdi(6'h22, d); chk("R1 control C", d, 32'h0700);
    rdi(6'h2B, d); chk("R1 baud count", d, 32'h0004);
    rdi(6'h00, d); chk("R1 rx empty read", d, 32'h4000);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(6'h22, 32'hFFFF_1234);
    rdi(6'h22, d); chk("R2 low16 control C", d, 32'h1234);
    wr(6'h29, 32'h0001_0022);
    rdi(6'h29, d); chk("R2 incr reads 0", d, 32'h0);
    rdi(6'h2B, d); chk("R2 incr lands in count", d, 32'h0022);
    wr(6'h2B, 32'h0000_0099);
    rdi(6'h2B, d); chk("R2 count write ignored", d, 32'h0022);
    wr(6'h2D, 32'h0000_FFFF);
    rdi(6'h2D, d); chk("R2 test write ignored", d, 32'h0060);
    rdi(6'h30, d); chk("R2 unmapped", d, 32'h0);
    rd(12'hF80, d); chk("R2 high unmapped", d, 32'h0);
    rd(12'h088, d); chk("R10 read latency", d, 32'h1234);
    @(negedge clk); chk("R10 rdata holds", rdata, 32'h1234);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    rx_beat(8'h41, 1'b0);
    chk("R3 rx_ready low", {31'b0, rx_ready}, 32'h0);
    rdi(6'h25, d); chk("R3 RRDY", d, 32'h6240);
    rdi(6'h26, d); chk("R3 RDR", d, 32'h4029);
    rdi(6'h2D, d); chk("R3 rx-empty clear", d, 32'h0040);
    rx_beat(8'h42, 1'b0);
    rdi(6'h00, d); chk("R4 valid read", d, 32'h8041);
    rdi(6'h25, d); chk("R4 RRDY cleared", d, 32'h6040);
    rdi(6'h2D, d); chk("R4 rx-empty set", d, 32'h0060);
    rdi(6'h00, d); chk("R4 empty read", d, 32'h0041);
    chk("R3 rx_ready back", {31'b0, rx_ready}, 32'h1);
  endtask

  task automatic t_break;
    logic [31:0] d;
    rx_beat(8'h00, 1'b1);
    rdi(6'h26, d); chk("R5 BRCD set", d, 32'h402D);
    wr(6'h26, 32'h0000_0001);
    rdi(6'h26, d); chk("R7 RDR ignores write", d, 32'h402D);
    wr(6'h26, 32'h0000_0004);
    rdi(6'h26, d); chk("R5 BRCD cleared", d, 32'h4029);
    rdi(6'h00, d); chk("R5 break word", d, 32'hD800);
    rdi(6'h26, d); chk("R4 RDR cleared", d, 32'h4028);
    wr(6'h25, 32'h0000_FFFF);
    rdi(6'h25, d); chk("R7 status A sticky bits", d, 32'h6040);
    wr(6'h26, 32'h0000_FFFF);
    rdi(6'h26, d); chk("R7 status B sticky bits", d, 32'h4028);
  endtask

  task automatic t_tx;
    logic [31:0] d;
    wr(6'h10, 32'h55);
    chk("R6 gated by enable", {31'b0, tx_valid}, 32'h0);
    wr(6'h21, 32'h0005);
    wr(6'h10, 32'h5A);
    chk("R6 tx_valid", {31'b0, tx_valid}, 32'h1);
    chk("R6 tx_data", {24'b0, tx_data}, 32'h5A);
    rdi(6'h25, d); chk("R6 TRDY low", d, 32'h4040);
    rdi(6'h26, d); chk("R6 TXDC low", d, 32'h4020);
    wr(6'h10, 32'h77);
    chk("R6 pending write dropped", {24'b0, tx_data}, 32'h5A);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R6 accepted", {31'b0, tx_valid}, 32'h0);
    rdi(6'h25, d); chk("R6 TRDY back", d, 32'h6040);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(6'h20, 32'h2000); chk("R9 TRDY enable", {31'b0, irq}, 32'h1);
    wr(6'h20, 32'h0200); chk("R9 RRDY idle", {31'b0, irq}, 32'h0);
    rx_beat(8'h33, 1'b0); chk("R9 RRDY raised", {31'b0, irq}, 32'h1);
    rdi(6'h00, d);        chk("R9 RRDY drained", {31'b0, irq}, 32'h0);
    wr(6'h20, 32'h0040); chk("R9 TXFE enable", {31'b0, irq}, 32'h1);
    wr(6'h20, 32'h0000); chk("R9 off", {31'b0, irq}, 32'h0);
    wr(6'h23, 32'h0008); chk("R9 TXDC enable", {31'b0, irq}, 32'h1);
    wr(6'h23, 32'h0001); chk("R9 RDR idle", {31'b0, irq}, 32'h0);
    rx_beat(8'h34, 1'b0); chk("R9 RDR raised", {31'b0, irq}, 32'h1);
    rdi(6'h00, d);        chk("R9 RDR drained", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_soft;
    logic [31:0] d;
    wr(6'h23, 32'h0008);
    wr(6'h24, 32'h1234);
    wr(6'h2C, 32'hABCD);
    wr(6'h20, 32'h0200);
    wr(6'h2A, 32'h0007);
    rx_beat(8'h66, 1'b0);
    wr(6'h21, 32'h0004);
    rdi(6'h21, d); chk("R8 srst reads 1", d, 32'h0005);
    rdi(6'h20, d); chk("R8 control A reset", d, 32'h0);
    rdi(6'h22, d); chk("R8 control C reset", d, 32'h0700);
    rdi(6'h2A, d); chk("R8 modulator reset", d, 32'h0);
    rdi(6'h2B, d); chk("R8 count reset", d, 32'h0004);
    rdi(6'h24, d); chk("R8 fifo kept", d, 32'h1234);
    rdi(6'h2C, d); chk("R8 msec kept", d, 32'hABCD);
    rdi(6'h23, d); chk("R8 control D kept", d, 32'h0008);
    chk("R8 irq via kept control D", {31'b0, irq}, 32'h1);
    rdi(6'h00, d); chk("R8 rx buffer reset", d, 32'h4000);
    rdi(6'h2D, d); chk("R8 test reset", d, 32'h0060);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_rx();
    t_break();
    t_tx();
    t_irq();
    t_soft();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule